// File: doc/BRIEF.md
# Truncating and Dithering Bit-Depth Reducer

This block narrows the colour depth of a pixel stream just before it leaves for a display link. Each cycle it may receive one pixel of three `W`-bit channels, packed red (or Cr) in the top field, green (or Y) in the middle and blue (or Cb) in the bottom. A valid strobe qualifies the pixel, and frame-start and line-start strobes come with it. The output keeps the full `W`-bit channel width. The bits below the selected depth are forced to zero, so later stages see an ordinary wide pixel that carries only 6, 8 or 10 significant bits per channel.

The block has three ways to reduce depth. Plain truncation drops the low bits. Rounding truncation adds half an output step first. Spatial dithering adds a pseudo-random value before the drop. The random value comes from a 28-bit LFSR per channel, each with its own seed. As an alternative, a static pattern can be taken from the seed input. A frame counter can change the pattern from one frame to the next, and its wrap point and bit order depend on the dither depth. Every sum saturates, so a bright pixel can never wrap to dark. All results are registered, which gives one cycle of latency.

Top module: `bitdepth_reducer`

## Requirements
- R1: With `trunc_en_i` and `dith_en_i` both low, `pix_o` equals the `pix_i` of the previous cycle. `valid_o` is `valid_i` delayed by one cycle, and `sof_o` and `sol_o` are each the corresponding input ANDed with `valid_i`, delayed by one cycle. `pix_o` changes only after a valid pixel, and after reset all outputs are zero.
- R2: With truncation enabled, dithering off and `trunc_mode_i`=0, each channel keeps its top 6 bits (`trunc_depth_i`=0) or its top 8 bits (`trunc_depth_i`=1), and its remaining k = W-depth low bits are zero.
- R3: With `trunc_mode_i`=1, each channel first has 2^(k-1) added. The sum saturates at all ones, and the low k bits are then cleared.
- R4: When `dith_en_i` is high it overrides truncation. `dith_depth_i` selects the output depth: 0 gives 6 bits, 1 gives 8 bits, and 2 or 3 gives 10 bits. The output is the saturated sum of the channel and d, with the low k bits cleared. d is the low k bits of (dither word XOR zero-extended frame offset).
- R5: The dither word is the low W bits of the LFSR state. The state steps as s' = {s[26:0], s[27]^s[2]} (polynomial x^28+x^3+1) once per valid pixel, and each pixel uses the state from before its own step.
- R6: In the first cycle after reset, and on any `seed_wr_i` while `frame_rand_i` is low, each generator loads its seed input, with a zero seed loaded as 1. On a load, a pixel in the same cycle still uses the old state.
- R7: While `frame_rand_i` is high, `seed_wr_i` is ignored and the generators keep stepping.
- R8: With `rgb_rand_i`=1 each channel uses its own generator (R, G, B seeds). With `rgb_rand_i`=0 all three channels use the red generator's word.
- R9: A 4-bit frame counter c starts at 0 and advances on each valid frame-start pixel. The new value applies to that pixel and to the rest of the frame. The counter goes to 0 after reaching its limit: 15 for dither depth 0 or 1, 3 for depth 2 or 3, and 0 when `frame_rand_i` is low. The frame offset is {c[1:0],c[3:2]} for depths 0 and 1, {c[0],c[1]} for depths 2 and 3, and 0 when `frame_rand_i` is low.
- R10: With `dith_mode_i`=1, the dither word is the low W bits of the selected channel's seed input (zero read as 1) instead of the LFSR state. The generators still step as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel valid |
| sof_i | input | 1 | First pixel of a frame |
| sol_i | input | 1 | First pixel of a line |
| pix_i | input | 3*W | Pixel {R/Cr, G/Y, B/Cb} |
| trunc_en_i | input | 1 | Truncation enable |
| trunc_depth_i | input | 1 | 0: 6 bits, 1: 8 bits |
| trunc_mode_i | input | 1 | 0: drop, 1: round |
| dith_en_i | input | 1 | Spatial dither enable |
| dith_mode_i | input | 1 | 0: LFSR word, 1: static seed word |
| dith_depth_i | input | 2 | 0: 6, 1: 8, 2/3: 10 bits |
| frame_rand_i | input | 1 | Frame randomisation enable |
| rgb_rand_i | input | 1 | Per-channel generators |
| seed_r_i | input | 28 | Red generator seed |
| seed_g_i | input | 28 | Green generator seed |
| seed_b_i | input | 28 | Blue generator seed |
| seed_wr_i | input | 1 | Seed reload request |
| valid_o | output | 1 | Output pixel valid |
| sof_o | output | 1 | Frame start, delayed |
| sol_o | output | 1 | Line start, delayed |
| pix_o | output | 3*W | Reduced pixel |

## Verification
The hardest behaviour to reach is the interaction between a seed reload, a valid pixel and a frame start that all fall in one cycle, with frame randomisation switching between on and off. Only that combination shows the ordering rules: the old state is used by the same-cycle pixel, while the new frame count applies to the frame-start pixel. The bench drives long runs in which the seed-write, frame-start, depth and random-source controls are randomised every cycle. A reference model follows all three generators and the counter, so any ordering slip makes the dithered pixels differ. Directed all-ones pixels test saturation under rounding and dithering.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int LFSR_W = 28;

  typedef enum logic [1:0] {OP_PASS, OP_TRUNC, OP_ROUND, OP_DITH} bdr_op_e;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[2]};
  endfunction
endpackage

// File: rtl/bdr_lfsr.sv
module bdr_lfsr
  import bdr_pkg::*;
#(
  parameter int W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              static_i,
  output logic [W-1:0]      word_o
);
  logic [LFSR_W-1:0] st_q, cur, seed_fix;
  logic              seeded_q;

  assign seed_fix = (seed_i == '0) ? LFSR_W'(1) : seed_i;
  assign cur      = seeded_q ? st_q : seed_fix;
  assign word_o   = static_i ? seed_fix[W-1:0] : cur[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= '0;
      seeded_q <= 1'b0;
    end else begin
      seeded_q <= 1'b1;
      if (load_i)     st_q <= seed_fix;
      else if (adv_i) st_q <= lfsr_step(cur);
      else            st_q <= cur;
    end
  end
endmodule

// File: rtl/bdr_frame_cnt.sv
module bdr_frame_cnt (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rand_en_i,
  input  logic [1:0] depth_i,
  output logic [3:0] off_o
);
  logic [3:0] cnt_q, cnt_nx, cnt_eff, cnt_max;
  logic [1:0] swap;

  always_comb begin
    if (!rand_en_i) begin
      cnt_max = 4'd0;
      swap    = 2'd0;
    end else if (depth_i < 2'd2) begin
      cnt_max = 4'd15;
      swap    = 2'd2;
    end else begin
      cnt_max = 4'd3;
      swap    = 2'd1;
    end
    cnt_nx  = (cnt_q >= cnt_max) ? 4'd0 : cnt_q + 4'd1;
    cnt_eff = start_i ? cnt_nx : cnt_q;
    case (swap)
      2'd2:    off_o = {cnt_eff[1:0], cnt_eff[3:2]};
      2'd1:    off_o = {2'b00, cnt_eff[0], cnt_eff[1]};
      default: off_o = 4'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= 4'd0;
    else if (start_i) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/bdr_chan.sv
module bdr_chan
  import bdr_pkg::*;
#(
  parameter int W = 12
) (
  input  bdr_op_e      op_i,
  input  logic [W-1:0] pix_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] dith_i,
  output logic [W-1:0] pix_o
);
  logic [W-1:0] addend, sat;
  logic [W:0]   sum;

  always_comb begin
    case (op_i)
      OP_ROUND: addend = (mask_i >> 1) + W'(1);
      OP_DITH:  addend = dith_i & mask_i;
      default:  addend = '0;
    endcase
    sum = {1'b0, pix_i} + {1'b0, addend};
    sat = sum[W] ? '1 : sum[W-1:0];
    case (op_i)
      OP_PASS:  pix_o = pix_i;
      OP_TRUNC: pix_o = pix_i & ~mask_i;
      default:  pix_o = sat & ~mask_i;
    endcase
  end
endmodule

// File: rtl/bitdepth_reducer.sv
module bitdepth_reducer
  import bdr_pkg::*;
#(
  parameter int W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              sol_i,
  input  logic [3*W-1:0]    pix_i,
  input  logic              trunc_en_i,
  input  logic              trunc_depth_i,
  input  logic              trunc_mode_i,
  input  logic              dith_en_i,
  input  logic              dith_mode_i,
  input  logic [1:0]        dith_depth_i,
  input  logic              frame_rand_i,
  input  logic              rgb_rand_i,
  input  logic [LFSR_W-1:0] seed_r_i,
  input  logic [LFSR_W-1:0] seed_g_i,
  input  logic [LFSR_W-1:0] seed_b_i,
  input  logic              seed_wr_i,
  output logic              valid_o,
  output logic              sof_o,
  output logic              sol_o,
  output logic [3*W-1:0]    pix_o
);
  localparam int NCH = 3;
  localparam int KW  = $clog2(W + 1);

  bdr_op_e           op;
  logic [KW-1:0]     k;
  logic [W-1:0]      mask;
  logic [3:0]        off;
  logic [LFSR_W-1:0] seeds [NCH];
  logic [W-1:0]      word  [NCH];
  logic [3*W-1:0]    red_d;

  assign seeds[0] = seed_r_i;
  assign seeds[1] = seed_g_i;
  assign seeds[2] = seed_b_i;

  always_comb begin
    if (dith_en_i)       op = OP_DITH;
    else if (trunc_en_i) op = trunc_mode_i ? OP_ROUND : OP_TRUNC;
    else                 op = OP_PASS;
    if (dith_en_i)
      k = (dith_depth_i == 2'd0) ? KW'(W-6) :
          (dith_depth_i == 2'd1) ? KW'(W-8) : KW'(W-10);
    else
      k = trunc_depth_i ? KW'(W-8) : KW'(W-6);
    mask = ~({W{1'b1}} << k);
  end

  bdr_frame_cnt i_frame_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (valid_i & sof_i),
    .rand_en_i (frame_rand_i),
    .depth_i   (dith_depth_i),
    .off_o     (off)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] sel_word;
    bdr_lfsr #(.W(W)) i_lfsr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .seed_i   (seeds[c]),
      .load_i   (seed_wr_i & ~frame_rand_i),
      .adv_i    (valid_i),
      .static_i (dith_mode_i),
      .word_o   (word[c])
    );
    assign sel_word = rgb_rand_i ? word[c] : word[0];
    // channel c sits at field NCH-1-c (red on top)
    bdr_chan #(.W(W)) i_chan (
      .op_i   (op),
      .pix_i  (pix_i[(NCH-1-c)*W +: W]),
      .mask_i (mask),
      .dith_i (sel_word ^ W'(off)),
      .pix_o  (red_d[(NCH-1-c)*W +: W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      sol_o   <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      sof_o   <= valid_i & sof_i;
      sol_o   <= valid_i & sol_i;
      if (valid_i) pix_o <= red_d;
    end
  end
endmodule

// File: rtl/bitdepth_reducer_chk.sv
module bitdepth_reducer_chk #(
  parameter int W = 12
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic           sof_i,
  input logic           sol_i,
  input logic [3*W-1:0] pix_i,
  input logic           trunc_en_i,
  input logic           trunc_depth_i,
  input logic           dith_en_i,
  input logic           valid_o,
  input logic           sof_o,
  input logic           sol_o,
  input logic [3*W-1:0] pix_o
);
  localparam logic [W-1:0] M6 = ~({W{1'b1}} << (W-6));
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> valid_o == $past(valid_i)); // R1
  AST_STROBE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (sof_o == $past(sof_i & valid_i)) && (sol_o == $past(sol_i & valid_i))); // R1
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(valid_i && !trunc_en_i && !dith_en_i) |-> pix_o == $past(pix_i)); // R1
  AST_TRUNC_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(valid_i && trunc_en_i && !dith_en_i && !trunc_depth_i) |->
      ((pix_o[2*W +: W] | pix_o[W +: W] | pix_o[0 +: W]) & M6) == '0); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(valid_i && dith_en_i) |->
      pix_o[3*W-1 -: 6] >= $past(pix_i[3*W-1 -: 6])); // R4
endmodule

bind bitdepth_reducer bitdepth_reducer_chk #(.W(W)) i_bdr_chk (.*);

// File: tb/test_bitdepth_reducer.sv
`timescale 1ns/1ps
module test_bitdepth_reducer;
  localparam int W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid, sof, sol, t_en, t_dep, t_mode, d_en, d_mode, f_rand, rgb, s_wr;
  logic [1:0] d_dep;
  logic [27:0] seed [3];
  logic [3*W-1:0] pix;
  logic valid_o, sof_o, sol_o;
  logic [3*W-1:0] pix_o;

  int n_tests = 0, n_fail = 0;

  // reference state
  logic [27:0] m_st [3];
  logic m_seeded;
  logic [3:0] m_fc;
  logic [3*W-1:0] e_pix;
  logic e_valid, e_sof, e_sol;

  always #4 clk = ~clk;

  bitdepth_reducer #(.W(W)) i_bitdepth_reducer (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .sol_i(sol),
    .pix_i(pix), .trunc_en_i(t_en), .trunc_depth_i(t_dep), .trunc_mode_i(t_mode),
    .dith_en_i(d_en), .dith_mode_i(d_mode), .dith_depth_i(d_dep),
    .frame_rand_i(f_rand), .rgb_rand_i(rgb),
    .seed_r_i(seed[0]), .seed_g_i(seed[1]), .seed_b_i(seed[2]), .seed_wr_i(s_wr),
    .valid_o(valid_o), .sof_o(sof_o), .sol_o(sol_o), .pix_o(pix_o)
  );

  function automatic logic [27:0] fix(input logic [27:0] s);
    return (s == 0) ? 28'd1 : s;
  endfunction

  function automatic logic [27:0] stp(input logic [27:0] s);
    return {s[26:0], s[27] ^ s[2]};
  endfunction

  function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W] ? {W{1'b1}} : s[W-1:0];
  endfunction

  function automatic logic [W-1:0] ref_ch(input logic [W-1:0] p, input logic [W-1:0] d,
                                          input int op, input int k);
    logic [W-1:0] m;
    m = W'((1 << k) - 1);
    case (op)
      0: return p;
      1: return p & ~m;
      2: return sat_add(p, W'(1 << (k - 1))) & ~m;
      default: return sat_add(p, d & m) & ~m;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // compute expectation for the inputs now driven, then advance the model
  task automatic model();
    int op, k;
    logic [27:0] cur [3];
    logic [3:0] mx, off;
    logic [W-1:0] w;
    for (int c = 0; c < 3; c++) cur[c] = m_seeded ? m_st[c] : fix(seed[c]);
    mx = !f_rand ? 4'd0 : (d_dep < 2) ? 4'd15 : 4'd3;
    if (valid && sof) m_fc = (m_fc >= mx) ? 4'd0 : m_fc + 4'd1;
    off = !f_rand ? 4'd0 : (d_dep < 2) ? {m_fc[1:0], m_fc[3:2]} : {2'b00, m_fc[0], m_fc[1]};
    op = d_en ? 3 : t_en ? (t_mode ? 2 : 1) : 0;
    k = d_en ? ((d_dep == 0) ? W-6 : (d_dep == 1) ? W-8 : W-10) : (t_dep ? W-8 : W-6);
    for (int c = 0; c < 3; c++) begin
      int sc;
      sc = rgb ? c : 0;
      w = d_mode ? fix(seed[sc])[W-1:0] : cur[sc][W-1:0];
      w = w ^ W'(off);
      if (valid) e_pix[(2-c)*W +: W] = ref_ch(pix[(2-c)*W +: W], w, op, k);
    end
    for (int c = 0; c < 3; c++)
      if (s_wr && !f_rand) m_st[c] = fix(seed[c]);
      else if (valid) m_st[c] = stp(cur[c]);
      else m_st[c] = cur[c];
    m_seeded = 1'b1;
    e_valid = valid; e_sof = valid & sof; e_sol = valid & sol;
  endtask

  task automatic step(input string tag);
    model();
    @(negedge clk);
    check("R1 valid", 64'(valid_o), 64'(e_valid));
    check("R1 strobes", 64'({sof_o, sol_o}), 64'({e_sof, e_sol}));
    if (e_valid) check(tag, 64'(pix_o), 64'(e_pix));
  endtask

  function automatic logic rb(input int v);
    return (v < 0) ? 1'($urandom_range(1)) : 1'(v);
  endfunction

  // -1 means randomise per cycle
  task automatic phase(input string tag, input int n, input int te, input int tm,
                       input int de, input int dm, input int fr, input int rg,
                       input int sw, input int sofp, input int eqch);
    for (int i = 0; i < n; i++) begin
      valid = ($urandom_range(3) != 0);
      sof = ($urandom_range(99) < sofp); sol = 1'($urandom_range(1));
      pix = {$urandom(), $urandom()};
      if (i % 9 == 0) pix = '1;
      if (eqch) pix = {3{pix[W-1:0]}};
      t_en = rb(te); t_mode = rb(tm); t_dep = 1'($urandom_range(1));
      d_en = rb(de); d_mode = rb(dm); d_dep = 2'($urandom_range(3));
      f_rand = rb(fr); rgb = rb(rg);
      s_wr = (sw < 0) ? ($urandom_range(7) == 0) : 1'(sw);
      if (s_wr) for (int c = 0; c < 3; c++) seed[c] = ($urandom_range(5) == 0) ? 28'd0 : 28'($urandom());
      step(tag);
      if (eqch && e_valid)
        check("R8 shared word", 64'(pix_o[2*W +: W] ^ pix_o[0 +: W]), 64'(0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    valid = 0; sof = 0; sol = 0; pix = '0; t_en = 0; t_dep = 0; t_mode = 0;
    d_en = 0; d_mode = 0; d_dep = 0; f_rand = 0; rgb = 1; s_wr = 0;
    seed[0] = 28'h0A5_3C71; seed[1] = 28'h1234567; seed[2] = 28'd0;
    m_seeded = 0; m_fc = 0; e_pix = '0;
    for (int c = 0; c < 3; c++) m_st[c] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'({valid_o, sof_o, sol_o}), 64'(0));
    check("R1 reset pix", 64'(pix_o), 64'(0));
    rst_n = 1'b1;
    // directed: pass-through, truncate, round saturation
    pix = {12'hABC, 12'h123, 12'hFFF}; valid = 1;
    step("R1 pass");
    t_en = 1; t_dep = 0; step("R2 trunc6");
    check("R2 trunc6 value", 64'(pix_o), 64'({12'hA80, 12'h100, 12'hFC0}));
    t_dep = 1; step("R2 trunc8");
    t_mode = 1; t_dep = 0; step("R3 round sat");
    check("R3 round value", 64'(pix_o), 64'({12'hAC0, 12'h140, 12'hFC0}));
    // frame-random seed write ignored (R7), then allowed (R6)
    d_en = 1; f_rand = 1; s_wr = 1; seed[0] = 28'hFFF_FFFF; step("R7 seed ignored");
    f_rand = 0; step("R6 seed load"); s_wr = 0; step("R6 after load");
    phase("R1", 200, 0, 0, 0, 0, 0, 1, 0, 5, 0);
    phase("R2", 200, 1, 0, 0, 0, 0, 1, 0, 5, 0);
    phase("R3", 200, 1, 1, 0, 0, 0, 1, 0, 5, 0);
    phase("R4", 300, -1, -1, 1, 0, 0, 1, 0, 5, 0);
    phase("R5", 300, 0, 0, 1, 0, 0, 1, 0, 0, 0);
    phase("R6", 400, 0, 0, 1, 0, 0, 1, -1, 5, 0);
    phase("R7", 400, 0, 0, 1, 0, 1, 1, -1, 20, 0);
    phase("R8", 300, 0, 0, 1, 0, -1, 0, -1, 10, 1);
    phase("R9", 600, 0, 0, 1, 0, 1, -1, 0, 40, 0);
    phase("R10", 300, 0, 0, 1, 1, -1, -1, -1, 20, 0);
    phase("R4 mixed", 3000, -1, -1, -1, -1, -1, -1, -1, 15, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule